// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block sits between up to sixteen peripheral request lines and eight transfer channels that share a single bus master. Each channel is given one request line and a burst size by software. Each enabled channel whose line is active competes for the master. The lowest-numbered competitor wins. A peripheral may ask for a single transfer or for a burst. The winner keeps the master for one transfer after a single request, or for the programmed burst size after a burst request. The arbiter then releases the master and arbitrates again.

The data mover reports each completed transfer with a one-cycle pulse. When a channel reaches the end of its block or hits a bus fault, it reports that with a per-channel event pulse. The arbiter latches these events as raw status bits. A software mask filters the raw bits, and a single interrupt line is raised while any filtered bit is set. Software reaches every setting and status word through a small synchronous write port and a combinational read port.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grantValid` and `irq` are low, and reads of addresses 0 to 3 return zero.
- R2: Request inputs pass through two flip-flop stages. A request that is raised while the arbiter is idle and the channel is enabled shows `grantValid` high after the third rising edge, and not before. With no grant strobe from arbitration, `grantValid` stays low.
- R3: When several enabled channels have active requests while the arbiter is idle, the channel with the lowest index wins. The losers are granted later, in index order, after each grant ends.
- R4: The burst code in config bits [5:4] maps 0→1, 1→4, 2→8 and 3→16 transfers. A burst request grants the coded count on `grantLen`. A single request alone grants 1. If both request types are active, the burst count applies.
- R5: A grant ends after exactly `grantLen` `xferDone` pulses. Until then, `grantCh` and `grantLen` do not change, and a request from a higher-priority channel does not pre-empt the grant.
- R6: A channel whose bit in the enable register (address 0, bit c for channel c) is zero is never granted, even with its request line active.
- R7: A `tcEvent[c]` pulse sets raw bit c, and an `errEvent[c]` pulse sets raw bit 8+c. The raw word is read at address 2. Writing ones to address 2 clears the matching raw bits. An event in the same cycle as a clear of the same bit leaves the bit set.
- R8: The mask register is at address 1 and uses the same bit layout as the raw word. Address 2 reads the raw word, and address 3 reads raw AND mask. `irq` is high exactly when the word at address 3 is non-zero.
- R9: `xferDone` pulses while no grant is active have no effect. The next grant still needs its full count of pulses.
- R10: The config register of channel c is at address 4+c. Bits [3:0] select which of the request lines drives channel c, and a request on any other line does not wake that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleReq | input | 16 | Single-transfer request per peripheral line (asynchronous) |
| burstReq | input | 16 | Burst request per peripheral line (asynchronous) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| xferDone | input | 1 | One pulse per transfer completed by the granted channel |
| tcEvent | input | 8 | Per-channel terminal-count event pulses |
| errEvent | input | 8 | Per-channel error event pulses |
| grantValid | output | 1 | The master is held by `grantCh` |
| grantCh | output | 3 | Index of the granted channel |
| grantLen | output | 5 | Number of transfers allowed for this grant |
| irq | output | 1 | Any masked status bit set |

## Verification
The assertions assume that `xferDone` only counts beats while a grant is active, and that event pulses and request lines are free-running inputs with no handshake of their own. The request lines are treated as levels, so nothing is assumed about their timing against the clock beyond the two-stage synchronizer. The stimulus drops a served line before it acknowledges the last beat, so a channel is never granted twice by accident. Acknowledgements are issued only while `grantValid` is high, except in the one deliberate idle-pulse test, and that test checks that those pulses are ignored.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;

  // widest channel index the control strobe can carry
  localparam int unsigned ARB_IDX_W = 4;
  // grant length width: largest burst is 16 transfers
  localparam int unsigned LEN_W = 5;

  // register addresses
  localparam int unsigned A_ENABLE = 0;
  localparam int unsigned A_MASK   = 1;
  localparam int unsigned A_RAW    = 2;
  localparam int unsigned A_MASKED = 3;
  localparam int unsigned A_CFG0   = 4;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 grantLoad;
    logic                 grantClear;
    logic [ARB_IDX_W-1:0] winCh;
    logic                 winBurst;
  } arb_ctrl_t;

  function automatic logic [LEN_W-1:0] burstBeats(input logic [1:0] code);
    case (code)
      2'd0:    burstBeats = LEN_W'(1);
      2'd1:    burstBeats = LEN_W'(4);
      2'd2:    burstBeats = LEN_W'(8);
      default: burstBeats = LEN_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/dma_arb_sync.sv
`timescale 1ns/1ps
module dma_arb_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stage1[i] <= 1'b0;
          dout[i]   <= 1'b0;
        end else begin
          stage1[i] <= din[i];
          dout[i]   <= stage1[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dma_arb_ctrl.sv
`timescale 1ns/1ps
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] eligible,
  input  logic [NUM_CH-1:0] burstPend,
  input  logic              xferDone,
  input  logic              lastBeat,
  output arb_ctrl_t         ctrl
);

  localparam int unsigned CH_W = $clog2(NUM_CH);

  arb_state_e state, stateNext;
  logic [CH_W-1:0] winIdx;

  // fixed priority: scan downwards so the lowest active index is kept
  always_comb begin
    winIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligible[c]) winIdx = CH_W'(c);
    end
  end

  always_comb begin
    ctrl.grantLoad  = (state == ARB_IDLE) && (|eligible);
    ctrl.grantClear = (state == ARB_BUSY) && xferDone && lastBeat;
    ctrl.winCh      = ARB_IDX_W'(winIdx);
    ctrl.winBurst   = burstPend[winIdx];
  end

  always_comb begin
    stateNext = state;
    case (state)
      ARB_IDLE: if (ctrl.grantLoad)  stateNext = ARB_BUSY;
      ARB_BUSY: if (ctrl.grantClear) stateNext = ARB_IDLE;
      default:  stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/dma_arb_dp.sv
`timescale 1ns/1ps
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_REQ = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ-1:0]         sglSync,
  input  logic [NUM_REQ-1:0]         bstSync,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [NUM_CH-1:0]          tcEvent,
  input  logic [NUM_CH-1:0]          errEvent,
  input  logic                       xferDone,
  input  arb_ctrl_t                  ctrl,
  output logic [NUM_CH-1:0]          eligible,
  output logic [NUM_CH-1:0]          burstPend,
  output logic                       lastBeat,
  output logic [NUM_CH-1:0]          chEnable,
  output logic [2*NUM_CH-1:0]        rawStat,
  output logic                       grantValid,
  output logic [$clog2(NUM_CH)-1:0]  grantCh,
  output logic [LEN_W-1:0]           grantLen,
  output logic                       irq
);

  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned SEL_W  = $clog2(NUM_REQ);
  localparam int unsigned STAT_W = 2 * NUM_CH;
  localparam int unsigned CFG_W  = SEL_W + 2;

  logic [STAT_W-1:0] maskReg;
  logic [SEL_W-1:0]  selReg  [NUM_CH];
  logic [1:0]        codeReg [NUM_CH];
  logic [LEN_W-1:0]  beatsLeft;
  logic [CH_W-1:0]   winIdx;
  logic [LEN_W-1:0]  loadLen;

  logic hitEnable, hitMask, hitRaw;
  assign hitEnable = regWrEn && (regAddr == ADDR_W'(A_ENABLE));
  assign hitMask   = regWrEn && (regAddr == ADDR_W'(A_MASK));
  assign hitRaw    = regWrEn && (regAddr == ADDR_W'(A_RAW));

  // per-channel config and request routing
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic hitCfg;
      assign hitCfg = regWrEn && (regAddr == ADDR_W'(A_CFG0 + c));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          selReg[c]  <= '0;
          codeReg[c] <= '0;
        end else if (hitCfg) begin
          selReg[c]  <= regWrData[SEL_W-1:0];
          codeReg[c] <= regWrData[SEL_W+1:SEL_W];
        end
      end

      assign burstPend[c] = bstSync[selReg[c]];
      assign eligible[c]  = chEnable[c] && (sglSync[selReg[c]] || bstSync[selReg[c]]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chEnable <= '0;
      maskReg  <= '0;
    end else begin
      if (hitEnable) chEnable <= regWrData[NUM_CH-1:0];
      if (hitMask)   maskReg  <= regWrData[STAT_W-1:0];
    end
  end

  // raw status: set by events, cleared by write-one; a new event beats a clear
  logic [STAT_W-1:0] clrBits;
  assign clrBits = hitRaw ? regWrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) rawStat <= '0;
    else       rawStat <= (rawStat & ~clrBits) | {errEvent, tcEvent};
  end

  assign irq = |(rawStat & maskReg);

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(A_ENABLE)) regRdData = DATA_W'(chEnable);
    if (regAddr == ADDR_W'(A_MASK))   regRdData = DATA_W'(maskReg);
    if (regAddr == ADDR_W'(A_RAW))    regRdData = DATA_W'(rawStat);
    if (regAddr == ADDR_W'(A_MASKED)) regRdData = DATA_W'(rawStat & maskReg);
    for (int k = 0; k < NUM_CH; k++) begin
      if (regAddr == ADDR_W'(A_CFG0 + k))
        regRdData = DATA_W'({codeReg[k], selReg[k]});
    end
  end

  // grant registers and beat counter
  assign winIdx  = ctrl.winCh[CH_W-1:0];
  assign loadLen = ctrl.winBurst ? burstBeats(codeReg[winIdx]) : LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantCh    <= '0;
      grantLen   <= '0;
      beatsLeft  <= '0;
    end else if (ctrl.grantLoad) begin
      grantValid <= 1'b1;
      grantCh    <= winIdx;
      grantLen   <= loadLen;
      beatsLeft  <= loadLen;
    end else begin
      if (ctrl.grantClear) grantValid <= 1'b0;
      if (grantValid && xferDone) beatsLeft <= beatsLeft - LEN_W'(1);
    end
  end

  assign lastBeat = grantValid && (beatsLeft == LEN_W'(1));

  logic [DATA_W-CFG_W-1:0] unusedWr;
  assign unusedWr = regWrData[DATA_W-1:CFG_W];

endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_REQ = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        singleReq,
  input  logic [NUM_REQ-1:0]        burstReq,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic                      xferDone,
  input  logic [NUM_CH-1:0]         tcEvent,
  input  logic [NUM_CH-1:0]         errEvent,
  output logic                      grantValid,
  output logic [$clog2(NUM_CH)-1:0] grantCh,
  output logic [LEN_W-1:0]          grantLen,
  output logic                      irq
);

  logic [2*NUM_REQ-1:0] reqSync;
  logic [NUM_CH-1:0]    eligible, burstPend, chEnable;
  logic [2*NUM_CH-1:0]  rawStat;
  logic                 lastBeat;
  arb_ctrl_t            ctrlStr;

  dma_arb_sync #(.WIDTH(2 * NUM_REQ)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({burstReq, singleReq}),
    .dout (reqSync)
  );

  dma_arb_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .eligible  (eligible),
    .burstPend (burstPend),
    .xferDone  (xferDone),
    .lastBeat  (lastBeat),
    .ctrl      (ctrlStr)
  );

  dma_arb_dp #(
    .NUM_CH  (NUM_CH),
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sglSync    (reqSync[NUM_REQ-1:0]),
    .bstSync    (reqSync[2*NUM_REQ-1:NUM_REQ]),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .tcEvent    (tcEvent),
    .errEvent   (errEvent),
    .xferDone   (xferDone),
    .ctrl       (ctrlStr),
    .eligible   (eligible),
    .burstPend  (burstPend),
    .lastBeat   (lastBeat),
    .chEnable   (chEnable),
    .rawStat    (rawStat),
    .grantValid (grantValid),
    .grantCh    (grantCh),
    .grantLen   (grantLen),
    .irq        (irq)
  );

endmodule

// File: rtl/dma_arb_chk.sv
`timescale 1ns/1ps
module dma_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      grantValid,
  input logic [$clog2(NUM_CH)-1:0] grantCh,
  input logic [LEN_W-1:0]          grantLen,
  input logic [NUM_CH-1:0]         chEnable,
  input logic [NUM_CH-1:0]         eligible,
  input arb_ctrl_t                 ctrlStr,
  input logic [NUM_CH-1:0]         tcEvent,
  input logic [NUM_CH-1:0]         errEvent,
  input logic [2*NUM_CH-1:0]       rawStat
);

  localparam int unsigned CH_W = $clog2(NUM_CH);

  // R5: grant fields frozen while the master is held
  a_r5_grant_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && $past(grantValid)) |-> ($stable(grantCh) && $stable(grantLen)));

  // R6: only enabled channels are loaded into the grant
  a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStr.grantLoad |-> chEnable[ctrlStr.winCh[CH_W-1:0]]);

  // R3: no lower-index channel was eligible when a winner was loaded
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStr.grantLoad |->
      ((eligible & ((NUM_CH'(1) << ctrlStr.winCh[CH_W-1:0]) - NUM_CH'(1))) == '0));

  // R4: grant length is one of the legal counts
  a_r4_legal_len: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (($countones(grantLen) == 1) && (grantLen != LEN_W'(2))));

  // R2: the grant only rises after a load strobe
  a_r2_grant_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && !ctrlStr.grantLoad) |=> !grantValid);

  // R7: an event always leaves its raw bit set, even against a clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |->
      ((rawStat & $past({errEvent, tcEvent})) == $past({errEvent, tcEvent})));

endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .grantValid (grantValid),
  .grantCh    (grantCh),
  .grantLen   (grantLen),
  .chEnable   (chEnable),
  .eligible   (eligible),
  .ctrlStr    (ctrlStr),
  .tcEvent    (tcEvent),
  .errEvent   (errEvent),
  .rawStat    (rawStat)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] singleReq, burstReq;
  logic        regWrEn;
  logic [3:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        xferDone;
  logic [7:0]  tcEvent, errEvent;
  logic        grantValid;
  logic [2:0]  grantCh;
  logic [4:0]  grantLen;
  logic        irq;

  int checks = 0;
  int errors = 0;

  typedef struct { int ch; int len; } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  dma_req_arbiter dut_i (
    .clk(clk), .rstN(rstN), .singleReq(singleReq), .burstReq(burstReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .xferDone(xferDone), .tcEvent(tcEvent),
    .errEvent(errEvent), .grantValid(grantValid), .grantCh(grantCh),
    .grantLen(grantLen), .irq(irq)
  );

  task automatic checkEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic regWrite(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = 32'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(int a, output int d);
    @(negedge clk);
    regAddr = 4'(a);
    #1 d = int'(regRdData);
  endtask

  function automatic int cfgWord(int sel, int code);
    return sel | (code << 4);
  endfunction

  task automatic pushExp(int ch, int len);
    exp_t e;
    e.ch = ch; e.len = len;
    expQ.push_back(e);
  endtask

  // wait for a grant, drop the served lines, optionally raise others, then ack beats
  task automatic serve(logic [15:0] dropS, logic [15:0] dropB, logic [15:0] raiseS, int expLen);
    int t = 0;
    int ch;
    while (!grantValid && t < 60) begin
      @(negedge clk);
      t++;
    end
    checkEq("R2", "grant arrives", int'(grantValid), 1);
    ch = int'(grantCh);
    singleReq = (singleReq & ~dropS) | raiseS;
    burstReq  = burstReq & ~dropB;
    repeat (3) @(negedge clk);
    for (int b = 0; b < expLen; b++) begin
      checkEq("R5", "grant held before beat", int'(grantValid), 1);
      checkEq("R5", "channel held", int'(grantCh), ch);
      xferDone = 1'b1;
      @(negedge clk);
      xferDone = 1'b0;
    end
    checkEq("R5", "grant released after last beat", int'(grantValid), 0);
  endtask

  // scoreboard monitor: compare each new grant with the queue head
  initial begin
    bit prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && grantValid && !prev) begin
        if (expQ.size() == 0) begin
          checkEq("R3", "unexpected grant channel", int'(grantCh), -1);
        end else begin
          e = expQ.pop_front();
          checkEq("R3", "granted channel", int'(grantCh), e.ch);
          checkEq("R4", "grant length", int'(grantLen), e.len);
        end
      end
      prev = grantValid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int rd;
    rstN = 1'b0; singleReq = '0; burstReq = '0; regWrEn = 1'b0;
    regAddr = '0; regWrData = '0; xferDone = 1'b0; tcEvent = '0; errEvent = '0;
    repeat (3) @(negedge clk);

    // R1 reset state
    checkEq("R1", "grantValid in reset", int'(grantValid), 0);
    checkEq("R1", "irq in reset", int'(irq), 0);
    rstN = 1'b1;
    for (int a = 0; a < 4; a++) begin
      regRead(a, rd);
      checkEq("R1", "register after reset", rd, 0);
    end

    // R10: channel 3 listens on line 5 only
    regWrite(4 + 3, cfgWord(5, 1));
    regWrite(0, 32'h08);
    regRead(4 + 3, rd);
    checkEq("R10", "config readback", rd, cfgWord(5, 1));
    @(negedge clk);
    singleReq[6] = 1'b1;
    repeat (6) @(negedge clk);
    checkEq("R10", "other line ignored", int'(grantValid), 0);
    singleReq[6] = 1'b0;
    repeat (3) @(negedge clk);

    // R2 latency and R4 single request grants one transfer
    pushExp(3, 1);
    singleReq[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkEq("R2", "no grant after two edges", int'(grantValid), 0);
    @(negedge clk);
    checkEq("R2", "grant after third edge", int'(grantValid), 1);
    serve(16'h0020, 16'h0000, 16'h0000, 1);

    // R4 burst codes
    pushExp(3, 4);
    burstReq[5] = 1'b1;
    serve(16'h0000, 16'h0020, 16'h0000, 4);

    regWrite(4 + 3, cfgWord(5, 3));
    pushExp(3, 16);
    burstReq[5] = 1'b1;
    serve(16'h0000, 16'h0020, 16'h0000, 16);

    // R4 both types active: burst count wins
    regWrite(4 + 3, cfgWord(5, 2));
    pushExp(3, 8);
    singleReq[5] = 1'b1; burstReq[5] = 1'b1;
    serve(16'h0020, 16'h0020, 16'h0000, 8);

    // R9 idle acks ignored; then burst code 0 still needs its one beat
    repeat (3) @(negedge clk);
    xferDone = 1'b1;
    repeat (3) @(negedge clk);
    xferDone = 1'b0;
    checkEq("R9", "idle acks create no grant", int'(grantValid), 0);
    regWrite(4 + 3, cfgWord(5, 0));
    pushExp(3, 1);
    burstReq[5] = 1'b1;
    serve(16'h0000, 16'h0020, 16'h0000, 1);

    // R3 fixed priority: channels 2 and 5 together
    regWrite(4 + 2, cfgWord(2, 0));
    regWrite(4 + 5, cfgWord(7, 1));
    regWrite(0, 32'h2C);
    pushExp(2, 1);
    pushExp(5, 4);
    @(negedge clk);
    singleReq[2] = 1'b1; burstReq[7] = 1'b1;
    serve(16'h0004, 16'h0000, 16'h0000, 1);
    serve(16'h0000, 16'h0080, 16'h0000, 4);

    // R5 no pre-emption: channel 0 rises during channel 6 burst
    regWrite(4 + 6, cfgWord(10, 1));
    regWrite(4 + 0, cfgWord(0, 0));
    regWrite(0, 32'h6D);
    pushExp(6, 4);
    pushExp(0, 1);
    burstReq[10] = 1'b1;
    serve(16'h0000, 16'h0400, 16'h0001, 4);
    serve(16'h0001, 16'h0000, 16'h0000, 1);

    // R6 disabled channel ignored until enabled
    regWrite(4 + 1, cfgWord(3, 0));
    @(negedge clk);
    singleReq[3] = 1'b1;
    repeat (10) @(negedge clk);
    checkEq("R6", "disabled channel not granted", int'(grantValid), 0);
    pushExp(1, 1);
    regWrite(0, 32'h6F);
    serve(16'h0008, 16'h0000, 16'h0000, 1);

    // R7 / R8 status
    @(negedge clk);
    tcEvent = 8'h04;
    @(negedge clk);
    tcEvent = 8'h00;
    regRead(2, rd);
    checkEq("R7", "raw after tc event", rd, 32'h0004);
    checkEq("R8", "irq masked off", int'(irq), 0);
    regWrite(1, 32'h0004);
    checkEq("R8", "irq with mask", int'(irq), 1);
    regRead(3, rd);
    checkEq("R8", "masked word", rd, 32'h0004);
    @(negedge clk);
    errEvent = 8'h20;
    @(negedge clk);
    errEvent = 8'h00;
    regRead(2, rd);
    checkEq("R7", "raw after error event", rd, 32'h2004);
    regRead(3, rd);
    checkEq("R8", "mask filters error bit", rd, 32'h0004);
    regWrite(2, 32'h0004);
    regRead(2, rd);
    checkEq("R7", "write-one clears", rd, 32'h2000);
    checkEq("R8", "irq drops after clear", int'(irq), 0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd2; regWrData = 32'h0080; tcEvent = 8'h80;
    @(negedge clk);
    regWrEn = 1'b0; tcEvent = 8'h00;
    regRead(2, rd);
    checkEq("R7", "event beats clear", rd, 32'h2080);
    regWrite(2, 32'h2080);
    regRead(2, rd);
    checkEq("R7", "final clear", rd, 0);

    repeat (4) @(negedge clk);
    checkEq("R3", "all expected grants seen", expQ.size(), 0);
    finishRun();
  end

endmodule